// File: doc/BRIEF.md
# Scanline Region Fill Engine

This block fills the interior of labelled outlines in a 3-bit-per-pixel label image, one image row at a time. Earlier stages mark each outline's left boundary pixels with an "opening" label and its right boundary pixels with a "closing" label. The engine then walks a row from left to right, reading one pixel per cycle. A two-state machine tracks whether the walk is outside or inside an outline, and each interior pixel is overwritten with a programmable fill code. The decision uses only the current pixel and the current state. Each pixel therefore costs one read and at most one write.

Three kinds of pass exist: one for each of two hand outlines and one for internal holes. Each pass uses its own pair of opening and closing codes, so the passes do not disturb each other's labels. The block contains several independent lanes, three by default. Each lane has its own synchronous simple-dual-port RAM port, so it can work on a different row in its own memory bank. The row length, pass select and fill code inputs are shared. Each lane captures them when its own row is accepted.

Top module: `scanfill_array`

## Requirements
- R1: An accepted row of length N ≥ 1 with base address B reads addresses B, B+1, …, B+N−1 on N consecutive cycles, exactly one per cycle. The first read is in the cycle after the go cycle.
- R2: The pass select picks the label pair. Pass 0 opens on 5 and closes on 4. Pass 1 opens on 7 and closes on 6. Passes 2 and 3 both open on 3 and close on 2. The scan state is outside at the start of every row.
- R3: Outside, a pixel equal to the opening code is written and the state becomes inside. Any other code is left untouched. Inside, a pixel equal to the closing code is left untouched and the state becomes outside. Any other code is written, including 0, 1 and other passes' labels.
- R4: Each write carries the fill code captured at row acceptance. A pixel holding the active closing code is never written.
- R5: When a pixel's read data returns in cycle t, its write, if any, is issued in cycle t+1 to the same address (two cycles after the read address). No pixel is written more than once per row.
- R6: For a row of length N ≥ 1 accepted in cycle g, done is a one-cycle pulse in cycle g+N+3, one cycle after the last possible write.
- R7: The error output becomes 1 together with done if the row ends in the inside state. Otherwise it is 0. It holds its value until the lane's next accepted go, which clears it.
- R8: A row of length 0 issues no reads or writes, pulses done in the cycle after go, and leaves the error output at 0.
- R9: Busy is high from the cycle after an accepted go until the cycle before done. A go while busy has no effect: the running row keeps its address, length, pass and fill code, and the other base region is not touched.
- R10: Lanes run independently and may overlap in time with different passes. Each lane samples the shared length, pass and fill inputs only at its own accepted go.
- R11: During reset, rd_en, wr_en, busy, done and err are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | LANES | Per-lane row start request |
| row_base | input | LANES*ADDR_W | Per-lane address of the row's first pixel |
| row_len | input | LEN_W | Row length in pixels, shared |
| pass_sel | input | 2 | Label pair select, shared |
| fill_code | input | 3 | Code written into interior pixels, shared |
| rd_en | output | LANES | Per-lane read strobe |
| rd_addr | output | LANES*ADDR_W | Per-lane read address |
| rd_data | input | LANES*3 | Per-lane read data, one cycle after the address |
| wr_en | output | LANES | Per-lane write strobe |
| wr_addr | output | LANES*ADDR_W | Per-lane write address |
| wr_data | output | LANES*3 | Per-lane write data |
| busy | output | LANES | Per-lane row in progress |
| done | output | LANES | Per-lane end-of-row pulse |
| err | output | LANES | Per-lane row ended inside an outline |

## Verification
Short hand-written rows set an opening and a closing label apart by plain pixels. Further directed rows place contour points and foreign pass labels inside an outline. These separate correct interior filling from filling that stops at, or skips, any non-zero code. Other directed rows end inside an outline, have zero length, use pass 3 against pass 2, or receive a second go mid-row with different shared inputs. These separate correct error reporting and input capture from designs that re-sample the shared inputs. Random rows, with opening and closing labels mixed among noise codes, are run on single lanes and on three overlapping lanes with different passes. They expose cross-lane interference and off-by-one errors in the read-to-write pipeline.

// File: rtl/scanfill_pkg.sv
package scanfill_pkg;

  localparam int PIX_W = 3;

  typedef logic [PIX_W-1:0] pix_t;

  typedef enum logic {
    SCAN_OUTSIDE = 1'b0,
    SCAN_INSIDE  = 1'b1
  } scan_state_t;

  // Label values shared with the labelling stage (decoded here).
  localparam pix_t LBL_HOLE_CLOSE = 3'd2;
  localparam pix_t LBL_HOLE_OPEN  = 3'd3;
  localparam pix_t LBL_A_CLOSE    = 3'd4;
  localparam pix_t LBL_A_OPEN     = 3'd5;
  localparam pix_t LBL_B_CLOSE    = 3'd6;
  localparam pix_t LBL_B_OPEN     = 3'd7;

  typedef struct packed {
    pix_t open_lbl;
    pix_t close_lbl;
    pix_t fill;
  } pass_cfg_t;

  function automatic pix_t open_label(input logic [1:0] pass);
    case (pass)
      2'd0:    return LBL_A_OPEN;
      2'd1:    return LBL_B_OPEN;
      default: return LBL_HOLE_OPEN;
    endcase
  endfunction

  function automatic pix_t close_label(input logic [1:0] pass);
    case (pass)
      2'd0:    return LBL_A_CLOSE;
      2'd1:    return LBL_B_CLOSE;
      default: return LBL_HOLE_CLOSE;
    endcase
  endfunction

endpackage

// File: rtl/scanfill_addr_gen.sv
module scanfill_addr_gen #(
  parameter int ADDR_W = 10,
  parameter int LEN_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [ADDR_W-1:0] base,
  input  logic [LEN_W-1:0]  len,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              last
);

  logic              en_q, en_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [LEN_W-1:0]  left_q, left_d;
  logic              step_ce;

  always_comb begin
    en_d   = en_q;
    addr_d = addr_q;
    left_d = left_q;
    if (launch) begin
      en_d   = 1'b1;
      addr_d = base;
      left_d = len - LEN_W'(1);
    end else if (en_q) begin
      if (left_q == '0) begin
        en_d = 1'b0;
      end else begin
        addr_d = addr_q + ADDR_W'(1);
        left_d = left_q - LEN_W'(1);
      end
    end
  end

  assign step_ce = launch | en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
    end else begin
      en_q <= en_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      left_q <= '0;
    end else if (step_ce) begin
      addr_q <= addr_d;
      left_q <= left_d;
    end
  end

  assign rd_en   = en_q;
  assign rd_addr = addr_q;
  assign last    = en_q && (left_q == '0);

endmodule

// File: rtl/scanfill_decide.sv
module scanfill_decide
  import scanfill_pkg::*;
(
  input  scan_state_t state,
  input  pix_t        pix,
  input  pix_t        open_lbl,
  input  pix_t        close_lbl,
  output logic        fill_now,
  output scan_state_t state_next
);

  always_comb begin
    fill_now   = 1'b0;
    state_next = state;
    case (state)
      SCAN_OUTSIDE: begin
        if (pix == open_lbl) begin
          fill_now   = 1'b1;
          state_next = SCAN_INSIDE;
        end
      end
      SCAN_INSIDE: begin
        if (pix == close_lbl) begin
          state_next = SCAN_OUTSIDE;
        end else begin
          fill_now = 1'b1;
        end
      end
      default: begin
        state_next = SCAN_OUTSIDE;
      end
    endcase
  end

endmodule

// File: rtl/scanfill_lane.sv
module scanfill_lane
  import scanfill_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LEN_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [ADDR_W-1:0] base,
  input  logic [LEN_W-1:0]  len,
  input  logic [1:0]        pass,
  input  pix_t              fill,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  pix_t              rd_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output pix_t              wr_data,
  output logic              busy,
  output logic              done,
  output logic              err
);

  logic        busy_q, busy_d;
  logic        done_q, done_d;
  logic        err_q, err_d;
  scan_state_t st_q, st_d;
  pass_cfg_t   cfg_q;

  logic              accept, empty_row, launch;
  logic              gen_last;
  logic              vld_q, lastrd_q, lastw_q;
  logic [ADDR_W-1:0] addr_dq;
  logic              wr_en_q;
  logic [ADDR_W-1:0] wr_addr_q;
  pix_t              wr_data_q;
  logic              fill_now;
  scan_state_t       st_after_pix;

  assign accept    = go & ~busy_q;
  assign empty_row = (len == '0);
  assign launch    = accept & ~empty_row;

  scanfill_addr_gen #(
    .ADDR_W(ADDR_W),
    .LEN_W (LEN_W)
  ) u_addr (
    .clk    (clk),
    .rst_n  (rst_n),
    .launch (launch),
    .base   (base),
    .len    (len),
    .rd_en  (rd_en),
    .rd_addr(rd_addr),
    .last   (gen_last)
  );

  scanfill_decide u_decide (
    .state     (st_q),
    .pix       (rd_data),
    .open_lbl  (cfg_q.open_lbl),
    .close_lbl (cfg_q.close_lbl),
    .fill_now  (fill_now),
    .state_next(st_after_pix)
  );

  // Control next-state
  always_comb begin
    busy_d = busy_q;
    err_d  = err_q;
    st_d   = st_q;
    done_d = lastw_q | (accept & empty_row);
    if (accept) begin
      err_d  = 1'b0;
      st_d   = SCAN_OUTSIDE;
      busy_d = ~empty_row;
    end else begin
      if (vld_q) begin
        st_d = st_after_pix;
      end
      if (lastw_q) begin
        err_d  = (st_q == SCAN_INSIDE);
        busy_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      st_q   <= SCAN_OUTSIDE;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      err_q  <= err_d;
      st_q   <= st_d;
    end
  end

  // Per-row configuration, captured on acceptance only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (accept) begin
      cfg_q.open_lbl  <= open_label(pass);
      cfg_q.close_lbl <= close_label(pass);
      cfg_q.fill      <= fill;
    end
  end

  // Data-return stage: aligns address and last flag with rd_data
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q    <= 1'b0;
      lastrd_q <= 1'b0;
      lastw_q  <= 1'b0;
    end else begin
      vld_q    <= rd_en;
      lastrd_q <= gen_last;
      lastw_q  <= vld_q & lastrd_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_dq <= '0;
    end else if (rd_en) begin
      addr_dq <= rd_addr;
    end
  end

  // Write stage: one cycle after read data returns
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en_q <= 1'b0;
    end else begin
      wr_en_q <= vld_q & fill_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_addr_q <= '0;
      wr_data_q <= '0;
    end else if (vld_q) begin
      wr_addr_q <= addr_dq;
      wr_data_q <= cfg_q.fill;
    end
  end

  assign wr_en   = wr_en_q;
  assign wr_addr = wr_addr_q;
  assign wr_data = wr_data_q;
  assign busy    = busy_q;
  assign done    = done_q;
  assign err     = err_q;

endmodule

// File: rtl/scanfill_array.sv
module scanfill_array
  import scanfill_pkg::*;
#(
  parameter int LANES  = 3,
  parameter int ADDR_W = 10,
  parameter int LEN_W  = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [LANES-1:0]         go,
  input  logic [LANES*ADDR_W-1:0]  row_base,
  input  logic [LEN_W-1:0]         row_len,
  input  logic [1:0]               pass_sel,
  input  logic [PIX_W-1:0]         fill_code,
  output logic [LANES-1:0]         rd_en,
  output logic [LANES*ADDR_W-1:0]  rd_addr,
  input  logic [LANES*PIX_W-1:0]   rd_data,
  output logic [LANES-1:0]         wr_en,
  output logic [LANES*ADDR_W-1:0]  wr_addr,
  output logic [LANES*PIX_W-1:0]   wr_data,
  output logic [LANES-1:0]         busy,
  output logic [LANES-1:0]         done,
  output logic [LANES-1:0]         err
);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    scanfill_lane #(
      .ADDR_W(ADDR_W),
      .LEN_W (LEN_W)
    ) u_lane (
      .clk    (clk),
      .rst_n  (rst_n),
      .go     (go[l]),
      .base   (row_base[l*ADDR_W +: ADDR_W]),
      .len    (row_len),
      .pass   (pass_sel),
      .fill   (fill_code),
      .rd_en  (rd_en[l]),
      .rd_addr(rd_addr[l*ADDR_W +: ADDR_W]),
      .rd_data(rd_data[l*PIX_W +: PIX_W]),
      .wr_en  (wr_en[l]),
      .wr_addr(wr_addr[l*ADDR_W +: ADDR_W]),
      .wr_data(wr_data[l*PIX_W +: PIX_W]),
      .busy   (busy[l]),
      .done   (done[l]),
      .err    (err[l])
    );
  end

endmodule

// File: rtl/scanfill_array_chk.sv
module scanfill_array_chk
  import scanfill_pkg::*;
#(
  parameter int LANES  = 3,
  parameter int ADDR_W = 10,
  parameter int LEN_W  = 9
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [LANES-1:0]         go,
  input logic [LANES*ADDR_W-1:0]  row_base,
  input logic [LEN_W-1:0]         row_len,
  input logic [1:0]               pass_sel,
  input logic [PIX_W-1:0]         fill_code,
  input logic [LANES-1:0]         rd_en,
  input logic [LANES*ADDR_W-1:0]  rd_addr,
  input logic [LANES*PIX_W-1:0]   rd_data,
  input logic [LANES-1:0]         wr_en,
  input logic [LANES*ADDR_W-1:0]  wr_addr,
  input logic [LANES*PIX_W-1:0]   wr_data,
  input logic [LANES-1:0]         busy,
  input logic [LANES-1:0]         done,
  input logic [LANES-1:0]         err
);

  for (genvar l = 0; l < LANES; l++) begin : g_chk
    pix_t fill_rec;
    pix_t close_rec;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        fill_rec  <= '0;
        close_rec <= '0;
      end else if (go[l] && !busy[l]) begin
        fill_rec  <= fill_code;
        close_rec <= close_label(pass_sel);
      end
    end

    assert_rd_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en[l] && $past(rd_en[l])) |->
        (rd_addr[l*ADDR_W +: ADDR_W] == $past(rd_addr[l*ADDR_W +: ADDR_W]) + ADDR_W'(1)));

    assert_wr_after_rd_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en[l] |-> ($past(rd_en[l], 2) &&
        ($past(rd_addr[l*ADDR_W +: ADDR_W], 2) == wr_addr[l*ADDR_W +: ADDR_W])));

    assert_fill_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en[l] |-> (wr_data[l*PIX_W +: PIX_W] == fill_rec));

    assert_close_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en[l] |-> ($past(rd_data[l*PIX_W +: PIX_W]) != close_rec));

    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done[l] |-> (!busy[l] && !rd_en[l]));

    assert_err_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err[l]) |-> done[l]);
  end

  assert_reset_quiet_R11: assert property (@(posedge clk)
    !rst_n |-> ((rd_en == '0) && (wr_en == '0) && (busy == '0) && (done == '0)));

endmodule

bind scanfill_array scanfill_array_chk #(
  .LANES (LANES),
  .ADDR_W(ADDR_W),
  .LEN_W (LEN_W)
) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .go       (go),
  .row_base (row_base),
  .row_len  (row_len),
  .pass_sel (pass_sel),
  .fill_code(fill_code),
  .rd_en    (rd_en),
  .rd_addr  (rd_addr),
  .rd_data  (rd_data),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .busy     (busy),
  .done     (done),
  .err      (err)
);

// File: tb/test_scanfill_array.sv
`timescale 1ns/1ps
module test_scanfill_array;
  localparam int LANES = 3;
  localparam int AW    = 10;
  localparam int LW    = 9;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic                 rst_n;
  logic [LANES-1:0]     go;
  logic [LANES*AW-1:0]  row_base;
  logic [LW-1:0]        row_len;
  logic [1:0]           pass_sel;
  logic [2:0]           fill_code;
  logic [LANES-1:0]     rd_en, wr_en, busy, done, err;
  logic [LANES*AW-1:0]  rd_addr, wr_addr;
  logic [LANES*3-1:0]   rd_data, wr_data;

  scanfill_array i_scanfill_array (
    .clk(clk), .rst_n(rst_n), .go(go), .row_base(row_base), .row_len(row_len),
    .pass_sel(pass_sel), .fill_code(fill_code), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .done(done), .err(err)
  );

  // Bank memories, loaded through a bench-only port
  logic [2:0] mem   [LANES][DEPTH];
  logic [2:0] model [LANES][DEPTH];
  logic       ld_en;
  int         ld_lane, ld_addr;
  logic [2:0] ld_val;

  always @(posedge clk) begin
    for (int l = 0; l < LANES; l++) begin
      if (!rst_n) begin
        for (int a = 0; a < DEPTH; a++) mem[l][a] <= 3'd0;
      end else begin
        rd_data[l*3 +: 3] <= mem[l][rd_addr[l*AW +: AW]];
        if (wr_en[l]) mem[l][wr_addr[l*AW +: AW]] <= wr_data[l*3 +: 3];
        if (ld_en && ld_lane == l) mem[l][ld_addr] <= ld_val;
      end
    end
  end

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  int go_cyc[LANES], rd_cnt[LANES], wr_cnt[LANES], done_cnt[LANES], done_at[LANES];
  int exp_addr[LANES], exp_wr[LANES], exp_len[LANES], exp_base[LANES];
  int exp_fill[LANES];
  bit exp_err[LANES];
  int h1a[LANES], h2a[LANES];
  bit h1e[LANES], h2e[LANES];

  // Port monitor
  always @(negedge clk) begin
    if (rst_n) begin
      for (int l = 0; l < LANES; l++) begin
        if (wr_en[l]) begin
          chk(h2e[l] && h2a[l] == int'(wr_addr[l*AW +: AW]), "R5", "write address vs read two cycles back",
              int'(wr_addr[l*AW +: AW]), h2a[l]);
          chk(int'(wr_data[l*3 +: 3]) == exp_fill[l], "R4", "write data", int'(wr_data[l*3 +: 3]), exp_fill[l]);
          wr_cnt[l]++;
        end
        h2e[l] = h1e[l]; h2a[l] = h1a[l];
        h1e[l] = rd_en[l]; h1a[l] = int'(rd_addr[l*AW +: AW]);
        if (rd_en[l]) begin
          chk(int'(rd_addr[l*AW +: AW]) == exp_addr[l], "R1", "read address", int'(rd_addr[l*AW +: AW]), exp_addr[l]);
          exp_addr[l]++;
          rd_cnt[l]++;
        end
        if (done[l]) begin
          done_cnt[l]++;
          done_at[l] = cyc;
        end
      end
    end
  end

  // Watchdog
  always @(negedge clk) begin
    if (cyc > 150000) begin
      chk(1'b0, "R6", "watchdog expired", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic load_pix(input int l, input int a, input int v);
    @(negedge clk);
    ld_en = 1'b1; ld_lane = l; ld_addr = a; ld_val = 3'(v);
    model[l][a] = 3'(v);
  endtask

  task automatic load_end();
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  // Octal literal: rightmost digit is pixel 0
  task automatic load_oct(input int l, input int base, input int n, input logic [47:0] codes);
    for (int i = 0; i < n; i++) load_pix(l, base + i, int'(codes[i*3 +: 3]));
    load_end();
  endtask

  function automatic int open_of(input int p);
    return (p == 0) ? 5 : (p == 1) ? 7 : 3;
  endfunction
  function automatic int close_of(input int p);
    return (p == 0) ? 4 : (p == 1) ? 6 : 2;
  endfunction

  task automatic gen_row(input int l, input int base, input int n, input int pass);
    for (int i = 0; i < n; i++) begin
      int r, v;
      r = $urandom_range(0, 9);
      v = (r < 5) ? 0 : (r == 5) ? open_of(pass) : (r == 6) ? close_of(pass) :
          (r == 7) ? 1 : $urandom_range(0, 7);
      load_pix(l, base + i, v);
    end
    load_end();
  endtask

  // Computes the expected row from R2/R3/R4 and drives go
  task automatic start_row(input int l, input int base, input int len, input int pass, input int fill);
    int s, e, st, nw;
    s = open_of(pass); e = close_of(pass); st = 0; nw = 0;
    for (int i = 0; i < len; i++) begin
      int p;
      p = int'(model[l][base + i]);
      if (st == 0) begin
        if (p == s) begin model[l][base + i] = 3'(fill); st = 1; nw++; end
      end else begin
        if (p == e) st = 0;
        else begin model[l][base + i] = 3'(fill); nw++; end
      end
    end
    exp_wr[l] = nw; exp_err[l] = (st == 1); exp_len[l] = len; exp_base[l] = base;
    exp_fill[l] = fill; exp_addr[l] = base;
    rd_cnt[l] = 0; wr_cnt[l] = 0; done_cnt[l] = 0;
    @(negedge clk);
    row_len = LW'(len); pass_sel = 2'(pass); fill_code = 3'(fill);
    row_base[l*AW +: AW] = AW'(base);
    go[l] = 1'b1;
    go_cyc[l] = cyc;
    @(negedge clk);
    go[l] = 1'b0;
  endtask

  task automatic cmp_region(input int l, input int lo, input int hi, input string req);
    int bad, first;
    bad = 0; first = -1;
    for (int a = lo; a <= hi; a++) begin
      if (mem[l][a] !== model[l][a]) begin
        bad++;
        if (first < 0) first = a;
      end
    end
    chk(bad == 0, req, "row contents mismatches (count)", bad, 0);
  endtask

  task automatic finish_row(input int l, input string req);
    int t, expd;
    t = 0;
    while (done_cnt[l] == 0 && t < 2000) begin @(negedge clk); t++; end
    @(negedge clk); @(negedge clk);
    expd = (exp_len[l] == 0) ? go_cyc[l] + 1 : go_cyc[l] + exp_len[l] + 3;
    chk(done_cnt[l] == 1 && done_at[l] == expd, (exp_len[l] == 0) ? "R8" : "R6",
        "done delay after go", done_at[l] - go_cyc[l], expd - go_cyc[l]);
    chk(rd_cnt[l] == exp_len[l], "R1", "read count", rd_cnt[l], exp_len[l]);
    chk(wr_cnt[l] == exp_wr[l], "R5", "write count", wr_cnt[l], exp_wr[l]);
    chk(err[l] == exp_err[l], "R7", "error flag", int'(err[l]), int'(exp_err[l]));
    chk(busy[l] == 1'b0, "R9", "busy after done", int'(busy[l]), 0);
    cmp_region(l, exp_base[l] - 1, exp_base[l] + exp_len[l], req);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; go = '0; row_base = '0; row_len = '0; pass_sel = '0; fill_code = '0;
    ld_en = 1'b0; ld_lane = 0; ld_addr = 0; ld_val = '0;
    for (int l = 0; l < LANES; l++) begin
      for (int a = 0; a < DEPTH; a++) model[l][a] = 3'd0;
      go_cyc[l] = 0; rd_cnt[l] = 0; wr_cnt[l] = 0; done_cnt[l] = 0; done_at[l] = 0;
      exp_addr[l] = 0; exp_wr[l] = 0; exp_len[l] = 0; exp_base[l] = 1; exp_fill[l] = 0; exp_err[l] = 0;
      h1a[l] = 0; h2a[l] = 0; h1e[l] = 0; h2e[l] = 0;
    end
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(rd_en == '0 && wr_en == '0 && busy == '0 && done == '0 && err == '0, "R11",
        "outputs in reset", int'({rd_en, wr_en, busy, done, err}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2/R3: pass 0 row 0 0 5 0 0 4 0, fill 1 -> pixels 2..4 written
    load_oct(0, 100, 7, 48'o0400500);
    start_row(0, 100, 7, 0, 1);
    chk(busy[0] == 1'b1, "R9", "busy after go", int'(busy[0]), 1);
    finish_row(0, "R2");

    // R3/R7: inside, codes 1, 7 and 2 are overwritten; row ends inside
    load_oct(0, 120, 6, 48'o542715);
    start_row(0, 120, 6, 0, 6);
    finish_row(0, "R3");

    // R7: next accepted go clears error; pass 1
    load_oct(0, 140, 5, 48'o06070);
    start_row(0, 140, 5, 1, 3);
    finish_row(0, "R7");

    // R2: pass 3 behaves as pass 2 (open 3, close 2), 5 inside is overwritten
    load_oct(1, 50, 7, 48'o0502503);
    start_row(1, 50, 7, 3, 4);
    finish_row(1, "R2");

    // R8: zero length row
    start_row(1, 300, 0, 0, 7);
    finish_row(1, "R8");

    // R9: go while busy is ignored, new shared inputs not taken
    load_oct(2, 600, 3, 48'o607);
    gen_row(2, 200, 40, 2);
    start_row(2, 200, 40, 2, 5);
    repeat (5) @(negedge clk);
    row_len = LW'(3); pass_sel = 2'd1; fill_code = 3'd7;
    row_base[2*AW +: AW] = AW'(600);
    go[2] = 1'b1;
    chk(busy[2] == 1'b1, "R9", "busy mid-row", int'(busy[2]), 1);
    @(negedge clk);
    go[2] = 1'b0;
    finish_row(2, "R9");
    cmp_region(2, 598, 605, "R9");

    // R10: three lanes overlapping with different passes
    gen_row(0, 400, 50, 0);
    gen_row(1, 400, 45, 1);
    gen_row(2, 400, 60, 2);
    start_row(0, 400, 50, 0, 6);
    start_row(1, 400, 45, 1, 2);
    start_row(2, 400, 60, 2, 3);
    finish_row(0, "R10");
    finish_row(1, "R10");
    finish_row(2, "R10");

    // Random single rows
    for (int k = 0; k < 30; k++) begin
      int l, b, n, p, f;
      l = $urandom_range(0, LANES - 1);
      b = $urandom_range(1, DEPTH - 70);
      n = $urandom_range(1, 64);
      p = $urandom_range(0, 3);
      f = $urandom_range(0, 7);
      gen_row(l, b, n, p);
      start_row(l, b, n, p, f);
      finish_row(l, "R3");
    end

    // Random overlapping batches
    for (int k = 0; k < 5; k++) begin
      int b[LANES], n[LANES];
      for (int l = 0; l < LANES; l++) begin
        b[l] = $urandom_range(1, DEPTH - 70);
        n[l] = $urandom_range(8, 64);
        gen_row(l, b[l], n[l], (l + k) % 4);
      end
      for (int l = 0; l < LANES; l++) start_row(l, b[l], n[l], (l + k) % 4, $urandom_range(0, 7));
      for (int l = 0; l < LANES; l++) finish_row(l, "R10");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule